// File: doc/BRIEF.md
# Zero-Turnaround SRAM Controller

This block connects a simple valid/ready request port to a synchronous SRAM that has a registered address and control path, flow-through read data and no idle cycle when the bus changes direction. Each request is a read or a write of either one word or four words. It carries a word address, packed write data and packed byte enables. The controller turns each request into memory commands, one command per clock. Write data goes out on the shared data bus in the cycle that follows each write command. Read data is sampled from the bus in the cycle that follows each read command and is returned on a response port with a valid flag and a last-beat flag.

Reads and writes can follow each other in consecutive cycles with no gap. A four-word burst is sent as one load command followed by three advance commands, and the memory's own counter steps through the words. When there is nothing to do, the controller sends a deselect. When the response port cannot accept a result, the controller holds the memory clock enable inactive and freezes its own pipeline in the same cycle, so the memory and the controller stay aligned.

Top module: `zbt_ctrl`

## Requirements
- R1: After reset, `mem_ce_n` is 1, `mem_doe` is 0, `rsp_valid` is 0, `mem_cen_n` is 0 and `req_ready` is 1.
- R2: A write that is accepted on edge P shows on the pins after P as a load: `mem_ce_n`=0, `mem_adv`=0, `mem_rw_n`=0, `mem_addr` = the request address and `mem_bw_n` = the inverse of beat 0's enables. After the next edge, `mem_doe`=1 and `mem_dout` carries beat 0 of the data. `mem_doe` is 0 in the cycle after any read command.
- R3: A read that is accepted on edge P is sampled from `mem_din` on edge P+2. From that edge on it is shown on `rsp_data` with `rsp_valid`=1. While `rsp_ready` is 0, the response stays valid and unchanged.
- R4: Single-word requests are accepted one per cycle with no idle cycles, in any mix of reads and writes. A read placed directly after a write to the same address returns the new data.
- R5: A burst request (`req_burst`=1) issues one load (`mem_adv`=0) and then three beats with `mem_adv`=1 and `mem_addr` unchanged. `req_ready` is 0 while the first three of those four commands are on the pins, and is 1 again while the last one is on the pins.
- R6: `mem_rw_n` keeps the value of the load for every advance beat of a burst.
- R7: Byte enables are active high on the request. Bit 4*k+l enables lane l (bits 9*l to 9*l+8) of beat k, and word k sits in bits 36*k to 36*k+35 of `req_wdata`. `mem_bw_n` carries the inverted enables of each beat, and lanes that are not enabled keep their old contents.
- R8: With no request pending, the pins carry a deselect: `mem_ce_n`=1, `mem_adv`=0, `mem_bw_n` all ones. `mem_doe` is 0 in the following cycle.
- R9: When `rsp_valid`=1 and `rsp_ready`=0, `mem_cen_n` is 1 and `req_ready` is 0. Every command pin and the data drive hold their values until the response is taken. No result is lost.
- R10: `rsp_last` is 1 for a single-word read and for the fourth beat of a burst read, and 0 for the other burst beats.
- R11: A burst ignores the two low address bits. It issues the four-aligned address, and its words go to aligned addresses +0 to +3 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word burst, 0 = single word |
| req_addr | input | AW | Word address |
| req_wdata | input | BEATS*DW | Packed write data, word k at k*DW |
| req_be | input | BEATS*LANES | Packed byte enables, active high |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | DW | Read word |
| rsp_last | output | 1 | Last word of a request |
| mem_cen_n | output | 1 | Memory clock enable, active low |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv | output | 1 | 1 = advance burst, 0 = load address |
| mem_rw_n | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Memory address |
| mem_bw_n | output | LANES | Byte write enables, active low |
| mem_dout | output | DW | Write data to the bus |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DW | Flow-through read data from the bus |

## Verification
The memory model in the bench keeps its own one-cycle data phase and burst counter. A full-array write sweep followed by a read/write/read interleave on every address shows whether the write data lag and the read sampling point are correct, because a lag that is one cycle off corrupts the read that follows. Bursts over all aligned blocks, each with a different lane pattern per beat, check that beats are ordered and masked per beat. A sweep of all sixteen enable masks over a known word shows whether each lane is kept or replaced. Holding back the response with two reads in flight shows whether the stall freezes both sides or drops the second read.

// File: rtl/zbt_ctrl_pkg.sv
package zbt_ctrl_pkg;

   // Tag carried alongside each memory command through the data phase
   typedef struct packed {
      logic vld;    // a real read or write command
      logic wr;     // direction of the command
      logic last;   // final word of its request
   } zbt_tag_t;

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
   import zbt_ctrl_pkg::*;
#(
   parameter int AW    = 17,
   parameter int DW    = 36,
   parameter int LANES = 4,
   parameter int BEATS = 4
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stall,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic                   req_burst,
   input  logic [AW-1:0]          req_addr,
   input  logic [BEATS*DW-1:0]    req_wdata,
   input  logic [BEATS*LANES-1:0] req_be,
   output logic [AW-1:0]          mem_addr,
   output logic                   mem_adv,
   output logic                   mem_rw_n,
   output logic                   mem_ce_n,
   output logic [LANES-1:0]       mem_bw_n,
   output zbt_tag_t               cmd_tag,
   output logic [DW-1:0]          cmd_wdata
);
   localparam int CW = $clog2(BEATS);

   logic [CW-1:0]          left_q;   // advance beats still to issue
   logic [CW-1:0]          idx_q;    // beat index of the next advance
   logic                   bwr_q;    // burst direction
   logic [BEATS*DW-1:0]    wbuf_q;
   logic [BEATS*LANES-1:0] bebuf_q;
   logic [DW-1:0]          beat_wd;
   logic [LANES-1:0]       beat_be;
   logic                   take;

   assign req_ready = !stall && (left_q == '0);
   assign take      = req_valid && req_ready;
   assign beat_wd   = wbuf_q[int'(idx_q)*DW +: DW];
   assign beat_be   = bebuf_q[int'(idx_q)*LANES +: LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_adv   <= 1'b0;
         mem_rw_n  <= 1'b1;
         mem_ce_n  <= 1'b1;
         mem_bw_n  <= '1;
         cmd_tag   <= '0;
         cmd_wdata <= '0;
         left_q    <= '0;
         idx_q     <= '0;
         bwr_q     <= 1'b0;
         wbuf_q    <= '0;
         bebuf_q   <= '0;
      end else if (!stall) begin
         if (take) begin
            mem_ce_n     <= 1'b0;
            mem_adv      <= 1'b0;
            mem_rw_n     <= !req_write;
            mem_addr     <= req_burst ? {req_addr[AW-1:CW], {CW{1'b0}}} : req_addr;
            mem_bw_n     <= req_write ? ~req_be[LANES-1:0] : '1;
            cmd_wdata    <= req_wdata[DW-1:0];
            cmd_tag.vld  <= 1'b1;
            cmd_tag.wr   <= req_write;
            cmd_tag.last <= !req_burst;
            left_q       <= req_burst ? CW'(BEATS-1) : '0;
            idx_q        <= CW'(1);
            bwr_q        <= req_write;
            wbuf_q       <= req_wdata;
            bebuf_q      <= req_be;
         end else if (left_q != '0) begin
            mem_ce_n     <= 1'b0;
            mem_adv      <= 1'b1;
            mem_bw_n     <= bwr_q ? ~beat_be : '1;
            cmd_wdata    <= beat_wd;
            cmd_tag.vld  <= 1'b1;
            cmd_tag.wr   <= bwr_q;
            cmd_tag.last <= (left_q == CW'(1));
            left_q       <= left_q - 1'b1;
            idx_q        <= idx_q + 1'b1;
         end else begin
            mem_ce_n <= 1'b1;
            mem_adv  <= 1'b0;
            mem_rw_n <= 1'b1;
            mem_bw_n <= '1;
            cmd_tag  <= '0;
         end
      end
   end

   // R5
   burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_adv |-> $stable(mem_addr));

   // R6
   burst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_adv |-> $stable(mem_rw_n));

   // R8
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (!mem_adv && (&mem_bw_n)));

endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
   import zbt_ctrl_pkg::*;
#(
   parameter int DW        = 36,
   parameter bit IDLE_ZERO = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  zbt_tag_t      cmd_tag,
   input  logic [DW-1:0] cmd_wdata,
   input  logic [DW-1:0] mem_din,
   input  logic          rsp_ready,
   output logic          stall,
   output logic          mem_doe,
   output logic [DW-1:0] mem_dout,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          rsp_last
);
   zbt_tag_t      dtag_q;     // command now in its data phase
   logic [DW-1:0] dout_nxt;
   logic          wr_cmd;

   assign stall  = rsp_valid && !rsp_ready;
   assign wr_cmd = cmd_tag.vld && cmd_tag.wr;

   generate
      if (IDLE_ZERO) begin : g_zero
         assign dout_nxt = wr_cmd ? cmd_wdata : '0;
      end else begin : g_hold
         assign dout_nxt = wr_cmd ? cmd_wdata : mem_dout;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dtag_q   <= '0;
         mem_doe  <= 1'b0;
         mem_dout <= '0;
      end else if (!stall) begin
         dtag_q   <= cmd_tag;
         mem_doe  <= wr_cmd;
         mem_dout <= dout_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_last  <= 1'b0;
      end else if (!stall) begin
         if (dtag_q.vld && !dtag_q.wr) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_din;
            rsp_last  <= dtag_q.last;
         end else begin
            rsp_valid <= 1'b0;
         end
      end
   end

   // R3
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
   import zbt_ctrl_pkg::*;
#(
   parameter int AW        = 17,
   parameter int DW        = 36,
   parameter int LANES     = 4,
   parameter int BEATS     = 4,
   parameter bit IDLE_ZERO = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic                   req_burst,
   input  logic [AW-1:0]          req_addr,
   input  logic [BEATS*DW-1:0]    req_wdata,
   input  logic [BEATS*LANES-1:0] req_be,
   output logic                   rsp_valid,
   input  logic                   rsp_ready,
   output logic [DW-1:0]          rsp_data,
   output logic                   rsp_last,
   output logic                   mem_cen_n,
   output logic                   mem_ce_n,
   output logic                   mem_adv,
   output logic                   mem_rw_n,
   output logic [AW-1:0]          mem_addr,
   output logic [LANES-1:0]       mem_bw_n,
   output logic [DW-1:0]          mem_dout,
   output logic                   mem_doe,
   input  logic [DW-1:0]          mem_din
);
   localparam int CW = $clog2(BEATS);

   initial begin
      lanes_div_chk: assert (DW % LANES == 0)
         else $error("data width must split evenly into lanes");
      beats_pow2_chk: assert (BEATS >= 2 && (BEATS & (BEATS - 1)) == 0)
         else $error("burst length must be a power of two");
      addr_room_chk: assert (AW > CW)
         else $error("address too narrow for burst alignment");
   end

   zbt_tag_t      cmd_tag;
   logic [DW-1:0] cmd_wdata;
   logic          stall;

   assign mem_cen_n = stall;

   zbt_issue #(.AW(AW), .DW(DW), .LANES(LANES), .BEATS(BEATS)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (stall),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_burst (req_burst),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .mem_addr  (mem_addr),
      .mem_adv   (mem_adv),
      .mem_rw_n  (mem_rw_n),
      .mem_ce_n  (mem_ce_n),
      .mem_bw_n  (mem_bw_n),
      .cmd_tag   (cmd_tag),
      .cmd_wdata (cmd_wdata)
   );

   zbt_datapath #(.DW(DW), .IDLE_ZERO(IDLE_ZERO)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_tag   (cmd_tag),
      .cmd_wdata (cmd_wdata),
      .mem_din   (mem_din),
      .rsp_ready (rsp_ready),
      .stall     (stall),
      .mem_doe   (mem_doe),
      .mem_dout  (mem_dout),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_last  (rsp_last)
   );

   // R2
   write_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_doe && !$past(mem_cen_n)) |-> $past(!mem_ce_n && !mem_rw_n));

   // R2
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(mem_cen_n) && $past(!mem_ce_n && mem_rw_n)) |-> !mem_doe);

   // R9
   stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cen_n |=> ($stable(mem_addr) && $stable(mem_ce_n) && $stable(mem_adv)
                     && $stable(mem_rw_n) && $stable(mem_doe) && $stable(mem_bw_n)));

endmodule

// File: tb/zbt_ctrl_test.sv
module zbt_ctrl_test;
   localparam int CLK_NS = 10;
   localparam int AW = 6, DW = 36, LANES = 4, BEATS = 4, LW = 9;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic                   req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
   logic [AW-1:0]          req_addr = '0;
   logic [BEATS*DW-1:0]    req_wdata = '0;
   logic [BEATS*LANES-1:0] req_be = '0;
   logic                   req_ready, rsp_valid, rsp_last;
   logic                   rsp_ready = 1'b1;
   logic                   hold_rsp = 1'b0;
   logic [DW-1:0]          rsp_data, mem_dout, mem_din;
   logic                   mem_cen_n, mem_ce_n, mem_adv, mem_rw_n, mem_doe;
   logic [AW-1:0]          mem_addr;
   logic [LANES-1:0]       mem_bw_n;

   zbt_ctrl #(.AW(AW), .DW(DW), .LANES(LANES), .BEATS(BEATS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
      .mem_cen_n(mem_cen_n), .mem_ce_n(mem_ce_n), .mem_adv(mem_adv),
      .mem_rw_n(mem_rw_n), .mem_addr(mem_addr), .mem_bw_n(mem_bw_n),
      .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din));

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: one-cycle data phase, linear burst counter
   logic [DW-1:0]    mdl [WORDS];
   logic [DW-1:0]    shadow [WORDS];
   logic             act_b = 1'b0, rwl = 1'b1, pv = 1'b0, prw_n = 1'b1;
   logic [AW-1:0]    base = '0, paddr = '0;
   logic [1:0]       cnt = '0;
   logic [LANES-1:0] pbw_n = '1;

   initial for (int i = 0; i < WORDS; i++) begin mdl[i] = '0; shadow[i] = '0; end

   always_comb mem_din = (pv && prw_n) ? mdl[paddr] : '0;

   always @(posedge clk) begin
      if (rst_n && !mem_cen_n) begin
         if (pv && !prw_n) begin
            chk(mem_doe == 1'b1, "R2 drive during write data phase", mem_doe, 1);
            for (int l = 0; l < LANES; l++)
               if (!pbw_n[l]) mdl[paddr][l*LW +: LW] <= mem_dout[l*LW +: LW];
         end
         if (pv && prw_n) chk(mem_doe == 1'b0, "R2 bus released in read phase", mem_doe, 0);
         if (!mem_adv) begin
            if (!mem_ce_n) begin
               act_b <= 1'b1; base <= mem_addr; cnt <= '0; rwl <= mem_rw_n;
               pv <= 1'b1; prw_n <= mem_rw_n; paddr <= mem_addr; pbw_n <= mem_bw_n;
            end else begin
               act_b <= 1'b0; pv <= 1'b0;
            end
         end else if (act_b) begin
            cnt <= cnt + 1'b1; pv <= 1'b1; prw_n <= rwl; pbw_n <= mem_bw_n;
            paddr <= {base[AW-1:2], base[1:0] + cnt + 2'd1};
         end else begin
            pv <= 1'b0;
         end
      end
   end

   // expected read results
   logic [DW-1:0] exp_d [512];
   logic          exp_l [512];
   int            wp = 0, rp = 0;

   always @(posedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (rp >= wp) chk(1'b0, "R3 unexpected response", rsp_data, 0);
         else begin
            chk(rsp_data == exp_d[rp], "R3/R4/R7 read data", rsp_data, exp_d[rp]);
            chk(rsp_last == exp_l[rp], "R10 last flag", rsp_last, exp_l[rp]);
            rp++;
         end
      end
   end

   always @(posedge clk) begin
      #2;
      rsp_ready = !hold_rsp;
   end

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic send(input bit wr, input bit bst, input logic [AW-1:0] a,
                       input logic [BEATS*DW-1:0] wd, input logic [BEATS*LANES-1:0] be);
      req_write = wr; req_burst = bst; req_addr = a; req_wdata = wd; req_be = be;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      for (int k = 0; k < (bst ? BEATS : 1); k++) begin
         logic [AW-1:0] ea;
         ea = bst ? {a[AW-1:2], 2'(k)} : a;
         if (wr) begin
            for (int l = 0; l < LANES; l++)
               if (be[k*LANES + l]) shadow[ea][l*LW +: LW] = wd[k*DW + l*LW +: LW];
         end else begin
            exp_d[wp] = shadow[ea];
            exp_l[wp] = !bst || (k == BEATS-1);
            wp++;
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] pat(input int i, input int s);
      return DW'((i + 1) * 36'h1_2345_6789 ^ (s * 36'h9_8765_4321));
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      int t0;
      logic [DW-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(mem_ce_n == 1'b1, "R1 chip enable idle", mem_ce_n, 1);
      chk(mem_doe == 1'b0, "R1 no drive", mem_doe, 0);
      chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
      chk(mem_cen_n == 1'b0, "R1 clock enabled", mem_cen_n, 0);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

      // R2 single write pin timing
      send(1'b1, 1'b0, 6'd5, {108'd0, pat(5, 1)}, 16'h000F);
      chk(!mem_ce_n && !mem_adv && !mem_rw_n, "R2 load write command", {mem_ce_n, mem_adv, mem_rw_n}, 0);
      chk(mem_addr == 6'd5, "R2 address", mem_addr, 5);
      chk(mem_bw_n == 4'b0000, "R2 byte enables", mem_bw_n, 0);
      @(negedge clk);
      chk(mem_doe == 1'b1, "R2 data driven one cycle later", mem_doe, 1);
      chk(mem_dout == pat(5, 1), "R2 write data", mem_dout, pat(5, 1));
      // R8 idle deselect
      chk(mem_ce_n && !mem_adv && (mem_bw_n == 4'hF), "R8 deselect pins", {mem_ce_n, mem_adv, mem_bw_n}, 6'b10_1111);
      @(negedge clk);
      chk(mem_doe == 1'b0, "R8 bus released after deselect", mem_doe, 0);

      // R3 read latency
      send(1'b0, 1'b0, 6'd5, '0, '0);
      chk(!mem_ce_n && mem_rw_n && !mem_adv, "R3 load read command", {mem_ce_n, mem_rw_n, mem_adv}, 3'b010);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3 not yet returned", rsp_valid, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R3 returned two edges after accept", rsp_valid, 1);
      chk(rsp_data == pat(5, 1), "R3 read data", rsp_data, pat(5, 1));

      // R5 R6 R7 R11 burst write at misaligned address
      send(1'b1, 1'b1, 6'd13, {pat(15, 2), pat(14, 2), pat(13, 2), pat(12, 2)}, 16'h8421);
      chk(!mem_adv && mem_addr == 6'd12, "R11 aligned load address", mem_addr, 12);
      chk(req_ready == 1'b0, "R5 ready low in burst", req_ready, 0);
      chk(mem_bw_n == 4'b1110, "R7 beat 0 enables", mem_bw_n, 4'b1110);
      for (int k = 1; k < BEATS; k++) begin
         @(negedge clk);
         chk(mem_adv == 1'b1 && mem_addr == 6'd12, "R5 advance beat holds address", {mem_adv, mem_addr}, {1'b1, 6'd12});
         chk(mem_rw_n == 1'b0, "R6 direction held in burst", mem_rw_n, 0);
         chk(mem_bw_n == ~(4'b0001 << k), "R7 per-beat enables", mem_bw_n, ~(4'b0001 << k));
         chk(req_ready == (k == BEATS-1), "R5 ready at burst end", req_ready, (k == BEATS-1));
      end
      @(negedge clk);
      chk(mem_ce_n == 1'b1, "R8 deselect after burst", mem_ce_n, 1);
      send(1'b0, 1'b1, 6'd14, '0, '0);
      @(negedge clk);
      chk(mem_rw_n == 1'b1 && mem_adv == 1'b1, "R6 read burst direction", {mem_rw_n, mem_adv}, 2'b11);

      // R9 stall with two reads in flight
      repeat (4) @(negedge clk);
      hold_rsp = 1'b1;
      @(negedge clk);
      send(1'b0, 1'b0, 6'd12, '0, '0);
      send(1'b0, 1'b0, 6'd5, '0, '0);
      @(negedge clk);
      held = rsp_data;
      for (int k = 0; k < 3; k++) begin
         chk(mem_cen_n == 1'b1, "R9 memory clock disabled", mem_cen_n, 1);
         chk(req_ready == 1'b0, "R9 ready low while stalled", req_ready, 0);
         chk(rsp_valid == 1'b1 && rsp_data == held, "R9 response held", rsp_data, held);
         @(negedge clk);
      end
      hold_rsp = 1'b0;
      repeat (4) @(negedge clk);
      chk(mem_cen_n == 1'b0, "R9 clock enabled after release", mem_cen_n, 0);

      // R4 full write sweep, then timed read/write/read interleave
      for (int i = 0; i < WORDS; i++) send(1'b1, 1'b0, AW'(i), {108'd0, pat(i, 3)}, 16'h000F);
      t0 = cyc;
      for (int i = 0; i < WORDS; i++) begin
         send(1'b0, 1'b0, AW'(i), '0, '0);
         send(1'b1, 1'b0, AW'(i), {108'd0, pat(i, 4)}, 16'h000F);
         send(1'b0, 1'b0, AW'(i), '0, '0);
      end
      chk(cyc - t0 == 3 * WORDS, "R4 no idle cycles", cyc - t0, 3 * WORDS);

      // R5 R7 R11 bursts over every block with distinct lane masks
      for (int b = 0; b < WORDS / BEATS; b++)
         send(1'b1, 1'b1, AW'(b * BEATS + (b % 4)),
              {pat(b, 8), pat(b, 7), pat(b, 6), pat(b, 5)},
              {4'(b), 4'(~b), 4'(b + 5), 4'(b ^ 9)});
      for (int b = 0; b < WORDS / BEATS; b++)
         send(1'b0, 1'b1, AW'(b * BEATS + 3 - (b % 4)), '0, '0);

      // R7 every single-word enable mask
      for (int m = 0; m < 16; m++) begin
         send(1'b1, 1'b0, 6'd40, {108'd0, pat(m, 10)}, 16'h000F);
         send(1'b1, 1'b0, 6'd40, {108'd0, pat(m, 11)}, 16'(m));
         send(1'b0, 1'b0, 6'd40, '0, '0);
      end

      for (int k = 0; k < 50 && rp != wp; k++) @(negedge clk);
      chk(rp == wp, "R3 all results returned", rp, wp);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule